// File: doc/BRIEF.md
# Two-Port Total-Store-Order Memory Subsystem

Two processor ports share one word-addressed memory. Each port has its own first-in first-out store buffer in front of that memory. A port issues loads, stores, fences and atomic swaps over a valid/ready handshake. Every accepted request returns one response pulse in the following cycle.

Stores are retired into the port's buffer at once. A load checks its own buffer first and otherwise reads the shared memory. Buffered stores drain in the background, one memory write per cycle, with round-robin choice between the two ports.

An atomic swap takes a single global lock, reads the old value and buffers the new one. It then waits until its own buffer is completely empty and releases the lock as the request completes. While a port holds the lock, the other port can neither drain nor load.

Top module: `tso_mem_sys`

## Requirements
- R1: Stores from one port reach shared memory in the order that port issued them. After the buffer is empty, the other port reads the last value stored to each address.
- R2: A load returns the data of the youngest entry in its own buffer with the same address. If no such entry exists, it returns the shared memory word.
- R3: Each buffer holds 4 entries. A store to a full buffer sees ready low until an entry drains.
- R4: A load is accepted while older stores to other addresses sit in its own buffer. A port sees its own buffered store before the other port can read it.
- R5: While one port holds the lock, the other port's buffer does not drain. The lock holder's own buffer may drain.
- R6: While one port holds the lock, a load from the other port sees ready low. When the lock is free, the load completes.
- R7: Op 3 (swap) takes the lock and returns the old word, including a value forwarded from its own buffer. It buffers the new word and holds ready low until its own buffer is empty. It releases the lock as it completes.
- R8: At most one buffer entry drains per cycle. When both ports are ready to drain, the choice alternates between them. Two ports storing every cycle therefore fill their buffers.
- R9: Op 2 (fence) sees ready low until the port's own buffer is empty. Its response data is 0.
- R10: After reset, both buffers are empty, the lock is free and every memory word reads 0.
- R11: Op encoding is 0 load, 1 store, 2 fence, 3 swap. An accepted request gives exactly one response pulse one cycle after the accepting edge. A store's response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | NPORT | request valid, one bit per port |
| req_op_i | input | NPORT x 2 | operation code per port |
| req_addr_i | input | NPORT x AW | word address per port |
| req_wdata_i | input | NPORT x DW | store or swap data per port |
| req_ready_o | output | NPORT | request accepted when high with valid |
| rsp_valid_o | output | NPORT | response pulse per port |
| rsp_data_o | output | NPORT x DW | load data or old swap value per port |

## Verification
The case of interest is a lock held by one port in the same cycles that the other port is pushing stores into its buffer. The bench starts a swap on port 0 in the same cycle that port 1 begins a run of five stores. Because the lock stops port 1 from draining, its buffer fills. The fifth store must therefore see ready low, and port 1's stores must then appear in memory in issue order. A second overlap loads on port 1 one cycle after port 0 takes the lock. That load must stall and must then return the swapped-in value.

// File: rtl/tso_pkg.sv
package tso_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_SWAP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    AT_IDLE,
    AT_ACCESS,
    AT_FLUSH
  } at_state_e;
endpackage

// File: rtl/tso_store_fifo.sv
module tso_store_fifo #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign count_o     = cnt_q;
  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];

  // scan oldest to youngest so the last match wins
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = rd_q + PW'(k);
      if ((CW'(k) < cnt_q) && (addr_q[idx] == look_addr_i)) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[idx];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q] <= push_addr_i;
      data_q[wr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/tso_rr_arb.sv
module tso_rr_arb #(
  parameter int N  = 2,
  localparam int IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    logic found;
    gnt_o = '0;
    ptr_d = ptr_q;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        ptr_d      = IW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tso_mem_sys.sv
module tso_mem_sys #(
  parameter int NPORT = 2,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORT-1:0]           req_valid_i,
  input  logic [NPORT-1:0][1:0]      req_op_i,
  input  logic [NPORT-1:0][AW-1:0]   req_addr_i,
  input  logic [NPORT-1:0][DW-1:0]   req_wdata_i,
  output logic [NPORT-1:0]           req_ready_o,
  output logic [NPORT-1:0]           rsp_valid_o,
  output logic [NPORT-1:0][DW-1:0]   rsp_data_o
);
  import tso_pkg::*;

  localparam int WORDS = 1 << AW;
  localparam int IW    = $clog2(NPORT);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [WORDS];
  logic          lock_held_q;
  logic [IW-1:0] lock_owner_q, gnt_idx;

  logic [NPORT-1:0] push_w, drain_req_w, drain_gnt_w;
  logic [NPORT-1:0] lock_req_w, lock_gnt_w, rel_w;
  logic [NPORT-1:0][AW-1:0] head_addr_w;
  logic [NPORT-1:0][DW-1:0] head_data_w;
  logic [NPORT-1:0][CW-1:0] buf_cnt_w;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    at_state_e     st_q;
    logic [DW-1:0] old_q, load_rd, rdat_q;
    logic          empty, full, hit, other_lock, ready, push, lreq, rel, rv_q;
    logic [DW-1:0] hit_data;

    tso_store_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_addr_i (req_addr_i[g]),
      .push_data_i (req_wdata_i[g]),
      .pop_i       (drain_gnt_w[g]),
      .look_addr_i (req_addr_i[g]),
      .empty_o     (empty),
      .full_o      (full),
      .count_o     (buf_cnt_w[g]),
      .head_addr_o (head_addr_w[g]),
      .head_data_o (head_data_w[g]),
      .hit_o       (hit),
      .hit_data_o  (hit_data)
    );

    assign other_lock = lock_held_q && (lock_owner_q != IW'(g));
    assign load_rd    = hit ? hit_data : mem_q[req_addr_i[g]];

    always_comb begin
      ready = 1'b0;
      push  = 1'b0;
      lreq  = 1'b0;
      rel   = 1'b0;
      unique case (st_q)
        AT_IDLE: if (req_valid_i[g]) begin
          unique case (op_e'(req_op_i[g]))
            OP_LOAD:  ready = !other_lock;
            OP_STORE: begin ready = !full; push = !full; end
            OP_FENCE: ready = empty;
            OP_SWAP:  lreq  = 1'b1;
          endcase
        end
        AT_ACCESS: push = !full;
        AT_FLUSH:  if (empty) begin ready = 1'b1; rel = 1'b1; end
        default: ;
      endcase
    end

    assign push_w[g]      = push;
    assign lock_req_w[g]  = lreq;
    assign rel_w[g]       = rel;
    assign drain_req_w[g] = !empty && !other_lock;
    assign req_ready_o[g] = ready;
    assign rsp_valid_o[g] = rv_q;
    assign rsp_data_o[g]  = rdat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= AT_IDLE;
        old_q  <= '0;
        rv_q   <= 1'b0;
        rdat_q <= '0;
      end else begin
        unique case (st_q)
          AT_IDLE:   if (lock_gnt_w[g]) st_q <= AT_ACCESS;
          AT_ACCESS: if (!full) begin st_q <= AT_FLUSH; old_q <= load_rd; end
          AT_FLUSH:  if (empty) st_q <= AT_IDLE;
          default:   st_q <= AT_IDLE;
        endcase
        rv_q <= req_valid_i[g] && ready;
        if (req_valid_i[g] && ready) begin
          if (op_e'(req_op_i[g]) == OP_LOAD)      rdat_q <= load_rd;
          else if (op_e'(req_op_i[g]) == OP_SWAP) rdat_q <= old_q;
          else                                    rdat_q <= '0;
        end
      end
    end
  end

  tso_rr_arb #(.N(NPORT)) u_drain_arb (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (drain_req_w), .gnt_o (drain_gnt_w)
  );

  tso_rr_arb #(.N(NPORT)) u_lock_arb (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_i (lock_req_w & {NPORT{!lock_held_q}}), .gnt_o (lock_gnt_w)
  );

  always_comb begin
    gnt_idx = '0;
    for (int p = 0; p < NPORT; p++) if (lock_gnt_w[p]) gnt_idx = IW'(p);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_held_q  <= 1'b0;
      lock_owner_q <= '0;
    end else if (|rel_w) begin
      lock_held_q  <= 1'b0;
    end else if (|lock_gnt_w) begin
      lock_held_q  <= 1'b1;
      lock_owner_q <= gnt_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (drain_gnt_w[p]) mem_q[head_addr_w[p]] <= head_data_w[p];
    end
  end
endmodule

// File: rtl/tso_mem_sys_chk.sv
module tso_mem_sys_chk #(
  parameter int NPORT = 2,
  parameter int DEPTH = 4,
  parameter int IW    = 1,
  parameter int CW    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NPORT-1:0]          req_valid_i,
  input logic [NPORT-1:0][1:0]     req_op_i,
  input logic [NPORT-1:0]          req_ready_o,
  input logic [NPORT-1:0]          rsp_valid_o,
  input logic                      lock_held_q,
  input logic [IW-1:0]             lock_owner_q,
  input logic [NPORT-1:0]          drain_gnt_w,
  input logic [NPORT-1:0]          push_w,
  input logic [NPORT-1:0][CW-1:0]  buf_cnt_w
);
  p_one_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drain_gnt_w));

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_cnt_w[g] == CW'(DEPTH)) |-> !push_w[g]);

    p_drain_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drain_gnt_w[g] && lock_held_q) |-> (lock_owner_q == IW'(g)));

    p_load_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[g] && req_op_i[g] == 2'd0 && lock_held_q && lock_owner_q != IW'(g))
        |-> !req_ready_o[g]);

    p_release_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_held_q && lock_owner_q == IW'(g) && req_valid_i[g] && req_ready_o[g])
        |-> (buf_cnt_w[g] == '0 && req_op_i[g] == 2'd3));

    p_fence_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[g] && req_op_i[g] == 2'd2 && req_ready_o[g]) |-> buf_cnt_w[g] == '0);

    p_rsp_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[g] && req_ready_o[g]) |=> rsp_valid_o[g]);
  end
endmodule

bind tso_mem_sys tso_mem_sys_chk #(
  .NPORT(NPORT), .DEPTH(DEPTH), .IW(IW), .CW(CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .lock_held_q  (lock_held_q),
  .lock_owner_q (lock_owner_q),
  .drain_gnt_w  (drain_gnt_w),
  .push_w       (push_w),
  .buf_cnt_w    (buf_cnt_w)
);

// File: tb/tso_mem_sys_bench.sv
module tso_mem_sys_bench;
  import tso_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [1:0]            req_valid_i = '0;
  logic [1:0][1:0]       req_op_i = '0;
  logic [1:0][AW-1:0]    req_addr_i = '0;
  logic [1:0][DW-1:0]    req_wdata_i = '0;
  logic [1:0]            req_ready_o;
  logic [1:0]            rsp_valid_o;
  logic [1:0][DW-1:0]    rsp_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;

  typedef struct {
    logic [DW-1:0] data;
    int            cyc;
    string         tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  tso_mem_sys u_tso_mem_sys (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_op_i (req_op_i),
    .req_addr_i (req_addr_i), .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o), .rsp_valid_o (rsp_valid_o),
    .rsp_data_o (rsp_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      if (rsp_valid_o[p]) begin
        exp_t e;
        if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
          check(1'b0, "R11 unexpected response", 1, 0);
        end else begin
          e = (p == 0) ? q0.pop_front() : q1.pop_front();
          check(rsp_data_o[p] == e.data, e.tag, int'(rsp_data_o[p]), int'(e.data));
          check(cyc_cnt == e.cyc, "R11 response cycle", cyc_cnt, e.cyc);
        end
      end
    end
  end

  task automatic do_op(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] exp,
                       input string tag, output int stalls);
    exp_t e;
    @(negedge clk_i);
    req_valid_i[p] = 1'b1;
    req_op_i[p]    = op;
    req_addr_i[p]  = a;
    req_wdata_i[p] = d;
    stalls = 0;
    forever begin
      #1;
      if (req_ready_o[p]) break;
      stalls++;
      @(negedge clk_i);
    end
    e.data = exp;
    e.cyc  = cyc_cnt + 1;
    e.tag  = tag;
    if (p == 0) q0.push_back(e);
    else        q1.push_back(e);
    @(posedge clk_i);
    #1 req_valid_i[p] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("[TB] FAIL watchdog: actual %0d expected %0d", cyc_cnt, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s, s0, s1, sa, sb;
    repeat (3) @(negedge clk_i);
    check(rsp_valid_o == 2'b00, "R10 no response in reset", int'(rsp_valid_o), 0);
    rst_ni = 1'b1;

    // R10: memory clear after reset
    fork
      do_op(0, OP_LOAD, 4'd3, 8'h0, 8'h00, "R10 mem zero p0", s);
      do_op(1, OP_LOAD, 4'd15, 8'h0, 8'h00, "R10 mem zero p1", sa);
    join

    // R4/R2: own store visible to own port before the other port
    fork
      begin
        do_op(0, OP_STORE, 4'd4, 8'h07, 8'h00, "R11 store rsp", s);
        do_op(0, OP_LOAD, 4'd4, 8'h0, 8'h07, "R4 own forward", s0);
      end
      begin
        @(negedge clk_i);
        do_op(1, OP_LOAD, 4'd4, 8'h0, 8'h00, "R4 other sees old", s1);
      end
    join
    check(s0 == 0, "R4 load not held by buffer", s0, 0);
    do_op(1, OP_LOAD, 4'd4, 8'h0, 8'h07, "R1 other sees drained", s);

    // R2: youngest matching entry under drain contention
    fork
      begin
        do_op(0, OP_STORE, 4'd1, 8'hA0, 8'h00, "R11 store rsp", s);
        do_op(0, OP_STORE, 4'd2, 8'h11, 8'h00, "R11 store rsp", s);
        do_op(0, OP_STORE, 4'd2, 8'h22, 8'h00, "R11 store rsp", s);
        do_op(0, OP_LOAD, 4'd2, 8'h0, 8'h22, "R2 youngest wins", s);
      end
      for (int i = 0; i < 4; i++)
        do_op(1, OP_STORE, AW'(8 + i), DW'(8'h81 + i), 8'h00, "R11 store rsp", sa);
    join

    // R9: fence waits for empty buffer
    do_op(0, OP_STORE, 4'd5, 8'h55, 8'h00, "R11 store rsp", s);
    do_op(0, OP_FENCE, 4'd0, 8'h0, 8'h00, "R9 fence rsp", s);
    check(s >= 1, "R9 fence stalled", s, 1);
    do_op(1, OP_LOAD, 4'd5, 8'h0, 8'h55, "R9 visible after fence", s);

    // R1: same-address order
    for (int i = 1; i <= 3; i++)
      do_op(0, OP_STORE, 4'd6, DW'(i), 8'h00, "R11 store rsp", s);
    do_op(0, OP_FENCE, 4'd0, 8'h0, 8'h00, "R9 fence rsp", s);
    do_op(1, OP_LOAD, 4'd6, 8'h0, 8'h03, "R1 last store wins", s);

    // R7: swap from memory and from own buffer
    do_op(0, OP_SWAP, 4'd5, 8'h99, 8'h55, "R7 swap old value", s);
    do_op(1, OP_LOAD, 4'd5, 8'h0, 8'h99, "R7 swap new value", s);
    do_op(0, OP_STORE, 4'd7, 8'h33, 8'h00, "R11 store rsp", s);
    do_op(0, OP_SWAP, 4'd7, 8'h44, 8'h33, "R7 swap forwarded old", s);
    do_op(1, OP_LOAD, 4'd7, 8'h0, 8'h44, "R7 swap flushed", s);

    // R6: other port load stalls while lock held
    fork
      do_op(0, OP_SWAP, 4'd12, 8'hC3, 8'h00, "R7 swap old value", s);
      begin
        @(negedge clk_i);
        do_op(1, OP_LOAD, 4'd12, 8'h0, 8'hC3, "R6 load after release", s1);
      end
    join
    check(s1 >= 1, "R6 load stalled by lock", s1, 1);

    // R5/R3: lock blocks port 1 drain while it keeps storing
    sb = 0;
    fork
      do_op(0, OP_SWAP, 4'd13, 8'h5A, 8'h00, "R7 swap old value", s);
      for (int i = 0; i < 5; i++) begin
        do_op(1, OP_STORE, AW'(8 + i), DW'(8'hB1 + i), 8'h00, "R11 store rsp", sa);
        sb += sa;
      end
    join
    check(sb >= 1, "R5 drain blocked by lock", sb, 1);
    check(sb >= 1, "R3 full buffer stalls store", sb, 1);
    do_op(1, OP_FENCE, 4'd0, 8'h0, 8'h00, "R9 fence rsp", s);
    for (int i = 0; i < 5; i++)
      do_op(0, OP_LOAD, AW'(8 + i), 8'h0, DW'(8'hB1 + i), "R1 stores after lock", s);

    // R8: both ports storing every cycle share one write per cycle
    s0 = 0; s1 = 0;
    fork
      for (int i = 0; i < 12; i++) begin
        do_op(0, OP_STORE, AW'(i % 8), DW'(8'h10 + i), 8'h00, "R11 store rsp", sa);
        s0 += sa;
      end
      for (int i = 0; i < 12; i++) begin
        do_op(1, OP_STORE, AW'(8 + i % 8), DW'(8'h30 + i), 8'h00, "R11 store rsp", sb);
        s1 += sb;
      end
    join
    check(s0 + s1 >= 1, "R8 single drain port throttles", s0 + s1, 1);
    fork
      do_op(0, OP_FENCE, 4'd0, 8'h0, 8'h00, "R9 fence rsp", s);
      do_op(1, OP_FENCE, 4'd0, 8'h0, 8'h00, "R9 fence rsp", sa);
    join
    for (int i = 0; i < 8; i++) begin
      int j0, j1;
      j0 = (i < 4) ? 8 + i : i;
      j1 = (i < 4) ? 8 + i : i;
      fork
        do_op(1, OP_LOAD, AW'(i), 8'h0, DW'(8'h10 + j0), "R8 port0 data in memory", s);
        do_op(0, OP_LOAD, AW'(8 + i), 8'h0, DW'(8'h30 + j1), "R8 port1 data in memory", sa);
      join
    end

    repeat (4) @(negedge clk_i);
    check(q0.size() == 0 && q1.size() == 0, "R11 all responses seen",
          q0.size() + q1.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule